// File: doc/BRIEF.md
# Reaction timer controller

This block runs a reaction-time game. It takes three button inputs: clear, start and stop. Each input is already debounced and arrives as a single-cycle pulse. The block drives one stimulus LED and a four-digit BCD value, which an external seven-segment driver displays as seconds with three decimals (D.DDD).

After reset the block is idle. A start press samples a free-running LFSR, and the sample sets a wait of random length. When the wait ends the LED lights and a millisecond counter starts from zero. A stop press freezes the count and turns the LED off. A clear press zeroes the display and returns the block to idle.

If the count reaches 9.999 s before stop is pressed, the count saturates there. If stop is pressed before the LED has lit, the block shows 9.999 as a penalty.

The millisecond tick comes from a divider of the clock. Its length in cycles is CLK_HZ/1000, written TPM below. CLK_HZ must be at least 2000.

Top module: `reaction_timer`

## Requirements
- R1: After reset the LED is off, digitsBcd is 0000, and the block waits in idle for a start press.
- R2: The LED lights exactly W*TPM cycles after the clock edge that samples start. W is a whole number of milliseconds from MIN_WAIT_MS to MIN_WAIT_MS+2^RAND_BITS-1.
- R3: While the LED is on, the count rises by one every TPM cycles. The first increment comes TPM cycles after the LED lights. Start presses have no effect in this phase.
- R4: A stop press while counting freezes the value and turns the LED off at the next cycle. The value is then held, ignoring start and stop, until clear.
- R5: If the count reaches 9999 it stays there, and the LED goes off one cycle later.
- R6: A stop press during the random wait sets digitsBcd to 9999 at the next cycle, with the LED off, and the value is then held.
- R7: digitsBcd holds one BCD digit per nibble, with the most significant digit (whole seconds) at bits 15:12. Every nibble stays within 0..9, and a carry passes into the next digit when a digit wraps from 9 to 0.
- R8: In any state a clear press makes digitsBcd 0000 with the LED off at the next cycle and returns the block to idle. Clear takes priority over start and stop.
- R9: dpSel is 4'b1000, so the decimal point is lit on the left-most digit only.
- R10: A stop press while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| btnClear | input | 1 | Clear pulse |
| btnStart | input | 1 | Start pulse |
| btnStop | input | 1 | Stop pulse |
| led | output | 1 | Stimulus LED |
| digitsBcd | output | 4*NUM_DIGITS | Displayed value, in BCD, in milliseconds |
| dpSel | output | NUM_DIGITS | Decimal point enable for each digit |

## Verification
Each button pulse takes effect at the edge that samples it, so the bench reads results at the falling edge that follows: state and LED changes after one edge, the penalty value after one edge, and a cleared display after one edge. The LED rise is counted in cycles from the edge that samples start, and the count must be a whole multiple of TPM inside the allowed window. Once the LED is seen, the bench places stop exactly M*TPM+1 edges after the rise, so the frozen value must equal M in BCD. For saturation it reads 9998 one cycle before the 9999th tick, 9999 with the LED still on at the tick, and the LED off one cycle later.

// File: rtl/rt_pkg.sv
package rt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } rtState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic divClear;    // restart millisecond divider phase
    logic waitLoad;    // capture random wait length
    logic waitStep;    // one millisecond of wait elapsed
    logic cntClear;    // zero the display counter
    logic cntInc;      // add one millisecond
    logic cntPenalty;  // force all nines
  } rtStrobe_t;

endpackage

// File: rtl/rt_ctrl.sv
module rt_ctrl
  import rt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       btnClear,
  input  logic       btnStart,
  input  logic       btnStop,
  input  logic       msTick,
  input  logic       waitDone,
  input  logic       cntAtMax,
  output rtStrobe_t  strobe,
  output rtState_e   stateQ,
  output logic       led
);

  rtState_e stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    if (btnClear) begin
      stateD          = ST_IDLE;
      strobe.cntClear = 1'b1;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (btnStart) begin
            stateD          = ST_WAIT;
            strobe.waitLoad = 1'b1;
            strobe.divClear = 1'b1;
          end
        end
        ST_WAIT: begin
          if (btnStop) begin
            stateD            = ST_DONE;
            strobe.cntPenalty = 1'b1;
          end else if (msTick) begin
            if (waitDone) begin
              stateD          = ST_RUN;
              strobe.divClear = 1'b1;
              strobe.cntClear = 1'b1;
            end else begin
              strobe.waitStep = 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (btnStop || cntAtMax) begin
            stateD = ST_DONE;
          end else if (msTick) begin
            strobe.cntInc = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign led = (stateQ == ST_RUN);

endmodule

// File: rtl/rt_datapath.sv
module rt_datapath
  import rt_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int NUM_DIGITS  = 4,
  parameter int MIN_WAIT_MS = 1000,
  parameter int RAND_BITS   = 11,
  parameter int LFSR_W      = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  rtStrobe_t               strobe,
  output logic                    msTick,
  output logic                    waitDone,
  output logic                    cntAtMax,
  output logic [4*NUM_DIGITS-1:0] digitsBcd
);

  localparam int TPM    = CLK_HZ / 1000;
  localparam int DIV_W  = $clog2(TPM);
  localparam int WAIT_W = $clog2(MIN_WAIT_MS + (1 << RAND_BITS)) + 1;

  // millisecond divider
  logic [DIV_W-1:0] divCnt;
  assign msTick = (divCnt == DIV_W'(TPM - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        divCnt <= '0;
    else if (strobe.divClear || msTick) divCnt <= '0;
    else                              divCnt <= divCnt + 1'b1;
  end

  // free-running Galois LFSR
  logic [LFSR_W-1:0] lfsr;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsr <= LFSR_W'(1);
    else       lfsr <= {1'b0, lfsr[LFSR_W-1:1]} ^ (lfsr[0] ? LFSR_TAPS : '0);
  end

  // random wait down-counter, in milliseconds
  logic [WAIT_W-1:0] waitCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      waitCnt <= '0;
    else if (strobe.waitLoad)
      waitCnt <= WAIT_W'(MIN_WAIT_MS - 1) + WAIT_W'(lfsr[RAND_BITS-1:0]);
    else if (strobe.waitStep && waitCnt != '0)
      waitCnt <= waitCnt - 1'b1;
  end
  assign waitDone = (waitCnt == '0);

  // cascaded BCD digits
  logic [NUM_DIGITS:0]   carry;
  logic [NUM_DIGITS-1:0] isNine;
  assign carry[0] = strobe.cntInc & ~cntAtMax;

  for (genvar gi = 0; gi < NUM_DIGITS; gi++) begin : g_digit
    logic [3:0] digit;
    assign isNine[gi]      = (digit == 4'd9);
    assign carry[gi+1]     = carry[gi] & isNine[gi];
    assign digitsBcd[4*gi +: 4] = digit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 digit <= 4'd0;
      else if (strobe.cntClear)  digit <= 4'd0;
      else if (strobe.cntPenalty) digit <= 4'd9;
      else if (carry[gi])        digit <= isNine[gi] ? 4'd0 : digit + 4'd1;
    end
  end

  assign cntAtMax = &isNine;

endmodule

// File: rtl/reaction_timer.sv
module reaction_timer
  import rt_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int NUM_DIGITS  = 4,
  parameter int MIN_WAIT_MS = 1000,
  parameter int RAND_BITS   = 11
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    btnClear,
  input  logic                    btnStart,
  input  logic                    btnStop,
  output logic                    led,
  output logic [4*NUM_DIGITS-1:0] digitsBcd,
  output logic [NUM_DIGITS-1:0]   dpSel
);

  rtStrobe_t strobe;
  rtState_e  curState;
  logic      msTick;
  logic      waitDone;
  logic      cntAtMax;

  rt_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .btnClear (btnClear),
    .btnStart (btnStart),
    .btnStop  (btnStop),
    .msTick   (msTick),
    .waitDone (waitDone),
    .cntAtMax (cntAtMax),
    .strobe   (strobe),
    .stateQ   (curState),
    .led      (led)
  );

  rt_datapath #(
    .CLK_HZ      (CLK_HZ),
    .NUM_DIGITS  (NUM_DIGITS),
    .MIN_WAIT_MS (MIN_WAIT_MS),
    .RAND_BITS   (RAND_BITS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .msTick    (msTick),
    .waitDone  (waitDone),
    .cntAtMax  (cntAtMax),
    .digitsBcd (digitsBcd)
  );

  assign dpSel = NUM_DIGITS'(1) << (NUM_DIGITS - 1);

endmodule

// File: rtl/rt_checker.sv
module rt_checker
  import rt_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    btnClear,
  input logic                    btnStop,
  input logic                    led,
  input logic [4*NUM_DIGITS-1:0] digitsBcd,
  input rtState_e                curState,
  input logic                    msTick
);

  localparam logic [4*NUM_DIGITS-1:0] ALL_NINES = {NUM_DIGITS{4'h9}};

  function automatic logic digitsLegal(logic [4*NUM_DIGITS-1:0] v);
    logic ok = 1'b1;
    for (int i = 0; i < NUM_DIGITS; i++) if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    btnClear |=> (digitsBcd == '0 && !led && curState == ST_IDLE));

  a_r6_penalty: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_WAIT && btnStop && !btnClear) |=> (digitsBcd == ALL_NINES && !led));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_DONE && !btnClear) |=> $stable(digitsBcd));

  a_r3_no_step_between_ticks: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_RUN && !msTick && !btnClear) |=> $stable(digitsBcd));

  a_r2_led_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(led) |-> $past(msTick));

  a_r5_cap_led_off: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_RUN && digitsBcd == ALL_NINES) |=> !led);

  a_r7_digits_legal: assert property (@(posedge clk) disable iff (!rstN)
    digitsLegal(digitsBcd));

endmodule

bind reaction_timer rt_checker #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .btnClear  (btnClear),
  .btnStop   (btnStop),
  .led       (led),
  .digitsBcd (digitsBcd),
  .curState  (curState),
  .msTick    (msTick)
);

// File: tb/reaction_timer_bench.sv
`timescale 1ns/1ps
module reaction_timer_bench;

  localparam int CLK_HZ = 4000;
  localparam int TPM    = CLK_HZ / 1000;
  localparam int MINW   = 200;
  localparam int RBITS  = 9;
  localparam int MAXW   = MINW + (1 << RBITS) - 1;
  localparam int WD     = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic btnClear = 1'b0, btnStart = 1'b0, btnStop = 1'b0;
  logic led;
  logic [15:0] digitsBcd;
  logic [3:0]  dpSel;

  int nChk = 0, nFail = 0, cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  reaction_timer #(.CLK_HZ(CLK_HZ), .NUM_DIGITS(4), .MIN_WAIT_MS(MINW), .RAND_BITS(RBITS))
    u_reaction_timer (.clk(clk), .rstN(rstN), .btnClear(btnClear), .btnStart(btnStart),
                      .btnStop(btnStop), .led(led), .digitsBcd(digitsBcd), .dpSel(dpSel));

  function automatic logic [15:0] toBcd(int v);
    logic [15:0] r;
    for (int i = 0; i < 4; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
  endtask

  // start, then measure cycles to LED rise (R2); returns at negedge after rise
  task automatic startAndWaitLed();
    int c = 0;
    pulse(btnStart);
    chk("R2 led off right after start", 32'(led), 0);
    forever begin
      @(posedge clk); c++;
      @(negedge clk);
      if (led) break;
    end
    chk("R2 wait multiple of ms", 32'(c % TPM), 0);
    chk("R2 wait in window", 32'((c >= MINW*TPM) && (c <= MAXW*TPM)), 1);
  endtask

  task automatic clearAndCheck(string tag);
    pulse(btnClear);
    chk({"R8 clear digits ", tag}, 32'(digitsBcd), 0);
    chk({"R8 clear led ", tag}, 32'(led), 0);
  endtask

  task automatic t_reset();
    chk("R1 reset digits", 32'(digitsBcd), 0);
    chk("R1 reset led", 32'(led), 0);
    chk("R9 decimal point", 32'(dpSel), 32'h8);
  endtask

  task automatic t_idleStop();
    pulse(btnStop);
    repeat (20) @(negedge clk);
    chk("R10 idle stop digits", 32'(digitsBcd), 0);
    chk("R10 idle stop led", 32'(led), 0);
  endtask

  task automatic t_measure(int m, bit holdStart);
    startAndWaitLed();
    if (holdStart) btnStart = 1'b1;
    repeat (m*TPM) @(posedge clk);
    @(negedge clk) btnStop = 1'b1;
    @(negedge clk) btnStop = 1'b0;
    btnStart = 1'b0;
    chk("R3 R7 measured value", 32'(digitsBcd), 32'(toBcd(m)));
    chk("R4 led off after stop", 32'(led), 0);
    repeat (5*TPM) @(negedge clk);
    pulse(btnStart);
    pulse(btnStop);
    repeat (5*TPM) @(negedge clk);
    chk("R4 value held in done", 32'(digitsBcd), 32'(toBcd(m)));
    chk("R4 led stays off", 32'(led), 0);
    clearAndCheck("after run");
  endtask

  task automatic t_cap();
    startAndWaitLed();
    repeat (9999*TPM - 1) @(posedge clk);
    @(negedge clk);
    chk("R5 one before cap", 32'(digitsBcd), 32'h9998);
    chk("R5 led still on", 32'(led), 1);
    @(negedge clk);
    chk("R5 reaches cap", 32'(digitsBcd), 32'h9999);
    @(negedge clk);
    chk("R5 led off after cap", 32'(led), 0);
    repeat (3*TPM) @(negedge clk);
    chk("R5 cap held", 32'(digitsBcd), 32'h9999);
    clearAndCheck("after cap");
  endtask

  task automatic t_penalty();
    pulse(btnStart);
    repeat (10) @(negedge clk);
    pulse(btnStop);
    chk("R6 penalty value", 32'(digitsBcd), 32'h9999);
    chk("R6 penalty led", 32'(led), 0);
    repeat ((MAXW + 2) * TPM) @(negedge clk);
    chk("R6 penalty held, led off", 32'({led, digitsBcd}), 32'h9999);
    clearAndCheck("after penalty");
  endtask

  task automatic t_clearInWait();
    pulse(btnStart);
    repeat (10) @(negedge clk);
    clearAndCheck("in wait");
    repeat ((MAXW + 2) * TPM) @(negedge clk);
    chk("R8 no led after clear in wait", 32'(led), 0);
  endtask

  task automatic t_clearInRun();
    startAndWaitLed();
    repeat (25*TPM) @(negedge clk);
    @(negedge clk) begin btnClear = 1'b1; btnStop = 1'b1; end
    @(negedge clk) begin btnClear = 1'b0; btnStop = 1'b0; end
    chk("R8 clear beats stop digits", 32'(digitsBcd), 0);
    chk("R8 clear in run led", 32'(led), 0);
  endtask

  initial begin
    @(posedge clk iff cyc == WD);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_idleStop();
    t_measure(1234, 1'b0);
    t_measure(1099, 1'b1);
    t_penalty();
    t_clearInWait();
    t_clearInRun();
    t_cap();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule